// File: doc/BRIEF.md
# Privileged Return and Trap-Check Unit

This block carries out the four privileged control operations of a small RISC-V style core. The operations are supervisor return, machine return, wait-for-interrupt and the address-translation fence. Each cycle the pipeline presents a one-hot operation strobe together with the current privilege level, the status register and the two saved exception PCs. One cycle later the block reports the outcome as exactly one of four results:

- a committed return, with the new PC, the new privilege level and the rewritten status word;
- a halt request;
- a one-cycle TLB flush pulse;
- an exception request with its cause code.

Before any state is touched, the block checks the privilege level and the three trap-control bits of the status register. These bits are trap-on-supervisor-return, timeout-wait and trap-virtual-memory. A return updates the interrupt-enable bit, the previous-enable bit and the previous-privilege field as a single step.

The return PC, next privilege and status outputs are registers. They change only when a return commits and hold their values otherwise. The surrounding core loads them into its own architectural state whenever `commit` is high.

Top module: `priv_ctl_exec`

## Requirements
- R1: After reset, `ret_pc` is 0, `next_priv` is 3 (machine), `status_out` is 0, and `commit`, `halt_req`, `tlb_flush` and `exc_valid` are low.
- R2: Supervisor return (`op_sel` = 4'b0001) at privilege 0 (user) raises `exc_valid` with cause 2 (illegal instruction) and leaves `ret_pc`, `next_priv` and `status_out` unchanged.
- R3: Machine return (`op_sel` = 4'b0010) at any privilege other than 3 raises cause 2.
- R4: When `cmp_en` is low and bits [1:0] of the selected saved PC are nonzero, a return that passes its other checks raises cause 0 (misaligned address) instead of committing. When `cmp_en` is high, these bits are not checked.
- R5: Supervisor return raises cause 2 when status bit 22 (trap-on-supervisor-return) is set.
- R6: Failed checks are prioritised in this order: privilege first, then status bit 22, then misalignment.
- R7: A committed supervisor return does all of the following:
  - sets `ret_pc` to `sepc_in`;
  - sets `next_priv` to {0, status bit 8};
  - copies bit 5 into bit 1;
  - clears bits 5 and 8;
  - keeps every other status bit.
- R8: A committed machine return does all of the following:
  - sets `ret_pc` to `mepc_in`;
  - sets `next_priv` to status bits [12:11];
  - copies bit 7 into bit 3;
  - clears bit 7 and bits [12:11];
  - keeps every other status bit.
- R9: Wait-for-interrupt (`op_sel` = 4'b0100) raises cause 2 when the privilege is 1 and status bit 21 is set. In every other case it pulses `halt_req` for one cycle.
- R10: The translation fence (`op_sel` = 4'b1000) raises cause 2 at privilege 0, or at privilege 1 with status bit 20 set. Otherwise it pulses `tlb_flush` for one cycle.
- R11: Every result appears exactly one cycle after the strobe. `exc_valid` and `commit` are never high together. The held outputs change only on `commit`.
- R12: A strobe with more than one bit set raises cause 2. An all-zero strobe produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| status_in | input | XLEN | Current status register |
| sepc_in | input | XLEN | Saved supervisor exception PC |
| mepc_in | input | XLEN | Saved machine exception PC |
| cmp_en | input | 1 | Compressed instructions are supported |
| op_sel | input | 4 | One-hot strobe: bit0 supervisor return, bit1 machine return, bit2 wait-for-interrupt, bit3 translation fence |
| ret_pc | output | XLEN | PC to resume at after a committed return |
| next_priv | output | 2 | Privilege level after a committed return |
| status_out | output | XLEN | Status word after a committed return |
| commit | output | 1 | One-cycle pulse: a return took effect |
| halt_req | output | 1 | One-cycle pulse: the core should wait for an interrupt |
| tlb_flush | output | 1 | One-cycle pulse: flush address translations |
| exc_valid | output | 1 | One-cycle pulse: raise an exception |
| exc_cause | output | 4 | Exception cause, valid with `exc_valid` |

## Verification
The bound checker watches several properties on every cycle:
- that at most one result is produced;
- that a strobe always yields exactly one result and an empty strobe yields none;
- that exceptions leave the held state untouched;
- that halt and flush pulses trace back to the right strobe;
- that committed returns without compressed support carry an aligned PC;
- that a machine return clears its previous-privilege field.

Some behaviours can only be shown by the bench's scenarios. These are the exact unstacked bit values, the priority among simultaneous failing checks, and the full sweep over privilege levels, trap-control combinations and PC alignments. The bench compares each of these against its own model of the requirements.

// File: rtl/priv_ctl_pkg.sv
package priv_ctl_pkg;

    // privilege levels
    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } lvl_e;

    // operation strobe bit positions
    localparam int unsigned OP_SRET  = 0;
    localparam int unsigned OP_MRET  = 1;
    localparam int unsigned OP_WFI   = 2;
    localparam int unsigned OP_FENCE = 3;
    localparam int unsigned NUM_OPS  = 4;

    // exception causes
    localparam int unsigned CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd0;

    // low PC bits that must be zero without compressed support
    localparam int unsigned ALIGN_BITS = 2;

    // status word field positions (decoded by the rest of the core)
    localparam int unsigned ST_SIE    = 1;
    localparam int unsigned ST_MIE    = 3;
    localparam int unsigned ST_SPIE   = 5;
    localparam int unsigned ST_MPIE   = 7;
    localparam int unsigned ST_SPP    = 8;
    localparam int unsigned ST_MPP_LO = 11;
    localparam int unsigned ST_MPP_HI = 12;
    localparam int unsigned ST_TVM    = 20;
    localparam int unsigned ST_TW     = 21;
    localparam int unsigned ST_TSR    = 22;

endpackage

// File: rtl/priv_ctl_check.sv
module priv_ctl_check
    import priv_ctl_pkg::*;
(
    input  logic [NUM_OPS-1:0]    op_sel,
    input  logic [1:0]            cur_priv,
    input  logic                  tsr_bit,
    input  logic                  tw_bit,
    input  logic                  tvm_bit,
    input  logic                  cmp_en,
    input  logic [ALIGN_BITS-1:0] spc_lo,
    input  logic [ALIGN_BITS-1:0] mpc_lo,
    output logic                  fault,
    output logic [CAUSE_W-1:0]    cause,
    output logic                  do_ret,
    output logic                  ret_from_m,
    output logic                  do_halt,
    output logic                  do_flush
);

    localparam logic [NUM_OPS-1:0] ONE = {{(NUM_OPS-1){1'b0}}, 1'b1};

    logic multi_hot;
    logic lvl_ge_s;
    logic lvl_is_s;
    logic lvl_is_m;
    logic s_misaligned;
    logic m_misaligned;

    assign multi_hot    = |(op_sel & (op_sel - ONE));
    assign lvl_ge_s     = (cur_priv != LVL_USER);
    assign lvl_is_s     = (cur_priv == LVL_SUPER);
    assign lvl_is_m     = (cur_priv == LVL_MACH);
    assign s_misaligned = !cmp_en && (|spc_lo);
    assign m_misaligned = !cmp_en && (|mpc_lo);

    always_comb begin
        fault      = 1'b0;
        cause      = CAUSE_MISALIGN;
        do_ret     = 1'b0;
        ret_from_m = 1'b0;
        do_halt    = 1'b0;
        do_flush   = 1'b0;
        if (multi_hot) begin
            fault = 1'b1;
            cause = CAUSE_ILLEGAL;
        end else if (op_sel[OP_SRET]) begin
            // order: privilege, trap-on-return, alignment
            if (!lvl_ge_s || tsr_bit) begin
                fault = 1'b1;
                cause = CAUSE_ILLEGAL;
            end else if (s_misaligned) begin
                fault = 1'b1;
                cause = CAUSE_MISALIGN;
            end else begin
                do_ret = 1'b1;
            end
        end else if (op_sel[OP_MRET]) begin
            if (!lvl_is_m) begin
                fault = 1'b1;
                cause = CAUSE_ILLEGAL;
            end else if (m_misaligned) begin
                fault = 1'b1;
                cause = CAUSE_MISALIGN;
            end else begin
                do_ret     = 1'b1;
                ret_from_m = 1'b1;
            end
        end else if (op_sel[OP_WFI]) begin
            if (lvl_is_s && tw_bit) begin
                fault = 1'b1;
                cause = CAUSE_ILLEGAL;
            end else begin
                do_halt = 1'b1;
            end
        end else if (op_sel[OP_FENCE]) begin
            if (!lvl_ge_s || (lvl_is_s && tvm_bit)) begin
                fault = 1'b1;
                cause = CAUSE_ILLEGAL;
            end else begin
                do_flush = 1'b1;
            end
        end
    end

endmodule

// File: rtl/priv_ctl_unstack.sv
module priv_ctl_unstack
    import priv_ctl_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            ret_from_m,
    input  logic [XLEN-1:0] status_in,
    input  logic [XLEN-1:0] sepc_in,
    input  logic [XLEN-1:0] mepc_in,
    output logic [XLEN-1:0] new_status,
    output logic [1:0]      new_priv,
    output logic [XLEN-1:0] new_pc
);

    always_comb begin
        new_status = status_in;
        if (ret_from_m) begin
            new_pc                            = mepc_in;
            new_priv                          = status_in[ST_MPP_HI:ST_MPP_LO];
            new_status[ST_MIE]                = status_in[ST_MPIE];
            new_status[ST_MPIE]               = 1'b0;
            new_status[ST_MPP_HI:ST_MPP_LO]   = LVL_USER;
        end else begin
            new_pc              = sepc_in;
            new_priv            = {1'b0, status_in[ST_SPP]};
            new_status[ST_SIE]  = status_in[ST_SPIE];
            new_status[ST_SPIE] = 1'b0;
            new_status[ST_SPP]  = 1'b0;
        end
    end

endmodule

// File: rtl/priv_ctl_exec.sv
module priv_ctl_exec
    import priv_ctl_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cur_priv,
    input  logic [XLEN-1:0]      status_in,
    input  logic [XLEN-1:0]      sepc_in,
    input  logic [XLEN-1:0]      mepc_in,
    input  logic                 cmp_en,
    input  logic [NUM_OPS-1:0]   op_sel,
    output logic [XLEN-1:0]      ret_pc,
    output logic [1:0]           next_priv,
    output logic [XLEN-1:0]      status_out,
    output logic                 commit,
    output logic                 halt_req,
    output logic                 tlb_flush,
    output logic                 exc_valid,
    output logic [CAUSE_W-1:0]   exc_cause
);

    typedef struct packed {
        logic [XLEN-1:0]    pc;
        logic [1:0]         priv;
        logic [XLEN-1:0]    status;
        logic               commit;
        logic               halt;
        logic               flush;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
    } out_t;

    logic               fault;
    logic [CAUSE_W-1:0] fault_cause;
    logic               do_ret;
    logic               ret_from_m;
    logic               do_halt;
    logic               do_flush;
    logic [XLEN-1:0]    uns_status;
    logic [1:0]         uns_priv;
    logic [XLEN-1:0]    uns_pc;

    out_t st_d, st_q;

    priv_ctl_check u_check (
        .op_sel     (op_sel),
        .cur_priv   (cur_priv),
        .tsr_bit    (status_in[ST_TSR]),
        .tw_bit     (status_in[ST_TW]),
        .tvm_bit    (status_in[ST_TVM]),
        .cmp_en     (cmp_en),
        .spc_lo     (sepc_in[ALIGN_BITS-1:0]),
        .mpc_lo     (mepc_in[ALIGN_BITS-1:0]),
        .fault      (fault),
        .cause      (fault_cause),
        .do_ret     (do_ret),
        .ret_from_m (ret_from_m),
        .do_halt    (do_halt),
        .do_flush   (do_flush)
    );

    priv_ctl_unstack #(.XLEN(XLEN)) u_unstack (
        .ret_from_m (ret_from_m),
        .status_in  (status_in),
        .sepc_in    (sepc_in),
        .mepc_in    (mepc_in),
        .new_status (uns_status),
        .new_priv   (uns_priv),
        .new_pc     (uns_pc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        st_d.halt   = 1'b0;
        st_d.flush  = 1'b0;
        st_d.exc    = 1'b0;
        st_d.cause  = '0;
        if (fault) begin
            st_d.exc   = 1'b1;
            st_d.cause = fault_cause;
        end else if (do_ret) begin
            st_d.commit = 1'b1;
            st_d.pc     = uns_pc;
            st_d.priv   = uns_priv;
            st_d.status = uns_status;
        end else begin
            st_d.halt  = do_halt;
            st_d.flush = do_flush;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.priv   <= LVL_MACH;
        end else begin
            st_q <= st_d;
        end
    end

    assign ret_pc     = st_q.pc;
    assign next_priv  = st_q.priv;
    assign status_out = st_q.status;
    assign commit     = st_q.commit;
    assign halt_req   = st_q.halt;
    assign tlb_flush  = st_q.flush;
    assign exc_valid  = st_q.exc;
    assign exc_cause  = st_q.cause;

endmodule

// File: rtl/priv_ctl_exec_chk.sv
module priv_ctl_exec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_sel,
    input logic [1:0] cur_priv,
    input logic       cmp_en,
    input logic       commit,
    input logic       halt_req,
    input logic       tlb_flush,
    input logic       exc_valid,
    input logic [3:0] exc_cause,
    input logic [1:0] next_priv,
    input logic [1:0] pc_lo,
    input logic [1:0] mpp_bits,
    input logic       mpie_bit,
    input logic [7:0] status_lo
);

    // R11
    excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, halt_req, tlb_flush, exc_valid}));

    // R11
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 4'b0) |=> ($countones({commit, halt_req, tlb_flush, exc_valid}) == 1));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'b0) |=> !(commit || halt_req || tlb_flush || exc_valid));

    // R12
    multi_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 4'b0 && !$onehot(op_sel)) |=> (exc_valid && exc_cause == 4'd2));

    // R11
    exc_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> ($stable(next_priv) && $stable(status_lo)));

    // R2
    sret_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'b0001 && cur_priv == 2'd0) |=> (exc_valid && exc_cause == 4'd2));

    // R3
    mret_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'b0010 && cur_priv != 2'd3) |=> (exc_valid && exc_cause == 4'd2));

    // R4
    aligned_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !$past(cmp_en)) |-> (pc_lo == 2'b00));

    // R8
    mret_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && $past(op_sel) == 4'b0010) |-> (mpp_bits == 2'b00 && !mpie_bit));

    // R9
    halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> ($past(op_sel) == 4'b0100));

    // R10
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> ($past(op_sel) == 4'b1000 && $past(cur_priv) != 2'd0));

endmodule

bind priv_ctl_exec priv_ctl_exec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .cur_priv  (cur_priv),
    .cmp_en    (cmp_en),
    .commit    (commit),
    .halt_req  (halt_req),
    .tlb_flush (tlb_flush),
    .exc_valid (exc_valid),
    .exc_cause (exc_cause),
    .next_priv (next_priv),
    .pc_lo     (ret_pc[1:0]),
    .mpp_bits  (status_out[12:11]),
    .mpie_bit  (status_out[7]),
    .status_lo (status_out[7:0])
);

// File: tb/priv_ctl_exec_test.sv
`timescale 1ns/1ps
module priv_ctl_exec_test;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cur_priv = '0;
    logic [XLEN-1:0] status_in = '0;
    logic [XLEN-1:0] sepc_in = '0;
    logic [XLEN-1:0] mepc_in = '0;
    logic            cmp_en = 1'b0;
    logic [3:0]      op_sel = '0;
    logic [XLEN-1:0] ret_pc;
    logic [1:0]      next_priv;
    logic [XLEN-1:0] status_out;
    logic            commit;
    logic            halt_req;
    logic            tlb_flush;
    logic            exc_valid;
    logic [3:0]      exc_cause;

    always #2.5 clk = ~clk;

    priv_ctl_exec #(.XLEN(XLEN)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_priv   (cur_priv),
        .status_in  (status_in),
        .sepc_in    (sepc_in),
        .mepc_in    (mepc_in),
        .cmp_en     (cmp_en),
        .op_sel     (op_sel),
        .ret_pc     (ret_pc),
        .next_priv  (next_priv),
        .status_out (status_out),
        .commit     (commit),
        .halt_req   (halt_req),
        .tlb_flush  (tlb_flush),
        .exc_valid  (exc_valid),
        .exc_cause  (exc_cause)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1357_9bdf;

    // expected held outputs and pulses
    logic [XLEN-1:0] e_pc = '0;
    logic [1:0]      e_priv = 2'd3;
    logic [XLEN-1:0] e_st = '0;
    logic            e_exc, e_commit, e_halt, e_flush;
    logic [3:0]      e_cause;

    // vector: op[19:16] priv[15:14] tsr[13] tw[12] tvm[11] cmp[10] pclo[9:8]
    //         exc[7] cause[6:3] commit[2] halt[1] flush[0]
    localparam logic [19:0] TBL [14] = '{
        {4'b0001, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
        {4'b0001, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
        {4'b0001, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
        {4'b0001, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
        {4'b0001, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0},
        {4'b0001, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0},
        {4'b0010, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
        {4'b0010, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0},
        {4'b0010, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0},
        {4'b0100, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
        {4'b0100, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0},
        {4'b1000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
        {4'b1000, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1},
        {4'b1000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0}
    };

    function automatic string tbl_tag(input int i);
        case (i)
            0:       return "R2";
            1:       return "R5";
            2, 3:    return "R6";
            4, 5, 7: return "R4";
            6:       return "R3";
            8:       return "R8";
            9, 10:   return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    // reference model built from the requirements
    task automatic model(input logic [3:0] op, input logic [1:0] pv,
                         input logic [31:0] st, input logic [31:0] sp,
                         input logic [31:0] mp, input logic cmp);
        logic [31:0] ns;
        e_exc = 0; e_cause = 0; e_commit = 0; e_halt = 0; e_flush = 0;
        ns = st;
        if ($countones(op) > 1) begin
            e_exc = 1; e_cause = 2;
        end else if (op == 4'b0001) begin
            if (pv == 0 || st[22]) begin e_exc = 1; e_cause = 2; end
            else if (!cmp && sp[1:0] != 0) begin e_exc = 1; e_cause = 0; end
            else begin
                e_commit = 1; e_pc = sp; e_priv = {1'b0, st[8]};
                ns[1] = st[5]; ns[5] = 0; ns[8] = 0; e_st = ns;
            end
        end else if (op == 4'b0010) begin
            if (pv != 3) begin e_exc = 1; e_cause = 2; end
            else if (!cmp && mp[1:0] != 0) begin e_exc = 1; e_cause = 0; end
            else begin
                e_commit = 1; e_pc = mp; e_priv = st[12:11];
                ns[3] = st[7]; ns[7] = 0; ns[12:11] = 0; e_st = ns;
            end
        end else if (op == 4'b0100) begin
            if (pv == 1 && st[21]) begin e_exc = 1; e_cause = 2; end
            else e_halt = 1;
        end else if (op == 4'b1000) begin
            if (pv == 0 || (pv == 1 && st[20])) begin e_exc = 1; e_cause = 2; end
            else e_flush = 1;
        end
    endtask

    // called at a falling edge: drive, wait one cycle, compare
    task automatic step(input logic [3:0] op, input logic [1:0] pv,
                        input logic [31:0] st, input logic [31:0] sp,
                        input logic [31:0] mp, input logic cmp, input string req);
        model(op, pv, st, sp, mp, cmp);
        op_sel = op; cur_priv = pv; status_in = st;
        sepc_in = sp; mepc_in = mp; cmp_en = cmp;
        @(negedge clk);
        chk(req, "exc_valid", exc_valid, e_exc);
        if (e_exc) chk(req, "exc_cause", exc_cause, e_cause);
        chk(req, "commit", commit, e_commit);
        chk(req, "halt_req", halt_req, e_halt);
        chk(req, "tlb_flush", tlb_flush, e_flush);
        chk("R11", "ret_pc", ret_pc, e_pc);
        chk("R11", "next_priv", next_priv, e_priv);
        chk("R11", "status_out", status_out, e_st);
    endtask

    task automatic step_rand(input logic [3:0] op, input logic [1:0] pv,
                             input logic tsr, input logic tw, input logic tvm,
                             input logic cmp, input logic [1:0] pclo, input string req);
        logic [31:0] st, sp, mp;
        st = seed; seed = nxt(seed);
        sp = {seed[31:2], pclo}; seed = nxt(seed);
        mp = {seed[31:2], pclo}; seed = nxt(seed);
        st[22] = tsr; st[21] = tw; st[20] = tvm;
        step(op, pv, st, sp, mp, cmp, req);
    endtask

    task automatic check_reset_state();
        chk("R1", "ret_pc", ret_pc, 0);
        chk("R1", "next_priv", next_priv, 3);
        chk("R1", "status_out", status_out, 0);
        chk("R1", "pulses", {commit, halt_req, tlb_flush, exc_valid}, 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // table of directed vectors
        for (int i = 0; i < 14; i++) begin
            logic [19:0] v;
            v = TBL[i];
            step_rand(v[19:16], v[15:14], v[13], v[12], v[11], v[10], v[9:8], tbl_tag(i));
            chk(tbl_tag(i), "table result",
                {exc_valid, (exc_valid ? exc_cause : 4'd0), commit, halt_req, tlb_flush},
                {v[7], v[6:3], v[2], v[1], v[0]});
        end

        // R7: explicit supervisor unstack: SPIE=1, SPP=1, SIE=0
        step(4'b0001, 2'd1, 32'h0000_0120, 32'h0000_4000, 32'h0, 1'b0, "R7");
        chk("R7", "next_priv value", next_priv, 2'd1);
        chk("R7", "status value", status_out, 32'h0000_0002);
        chk("R7", "ret_pc value", ret_pc, 32'h0000_4000);
        // R8: explicit machine unstack: MPIE=1, MPP=01
        step(4'b0010, 2'd3, 32'h0000_0880, 32'h0, 32'h0000_8000, 1'b0, "R8");
        chk("R8", "next_priv value", next_priv, 2'd1);
        chk("R8", "status value", status_out, 32'h0000_0008);
        // R2: illegal return leaves held state
        step(4'b0001, 2'd0, 32'h0000_0120, 32'h0000_1000, 32'h0, 1'b0, "R2");
        chk("R2", "status held", status_out, 32'h0000_0008);
        chk("R2", "priv held", next_priv, 2'd1);

        // sweep: every strobe, privilege, trap-control set, compressed flag, PC alignment
        for (int op = 0; op < 16; op++)
            for (int pv = 0; pv < 4; pv++)
                for (int tb = 0; tb < 8; tb++)
                    for (int c = 0; c < 2; c++)
                        for (int pl = 0; pl < 4; pl++)
                            step_rand(4'(op), 2'(pv), tb[2], tb[1], tb[0], c[0], 2'(pl),
                                      (op == 0 || $countones(op) > 1) ? "R12" : "R6");

        // R1: reset in mid-run
        op_sel = '0;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        e_pc = '0; e_priv = 2'd3; e_st = '0;
        step_rand(4'b0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, "R12");

        finish_run();
    end

endmodule